// File: doc/BRIEF.md
# Overlay Window Framebuffer Fetch Address Generator

This block walks the visible rectangle of one overlay window inside a framebuffer held in memory and issues a burst read request for each piece of it. Configuration inputs give the base address, the padded width of the whole buffer in pixels, the X and Y position where reading starts, the size of the visible overlay and a pixel storage code. Each visible line is split into word bursts. The line pitch comes from the padded buffer width, not from the overlay width.

A one-cycle `frame_start` pulse starts the walk at the first visible row. Requests go out over a valid/ready handshake. After the last burst of the last row is accepted, `done` rises and stays high until the next frame starts. Memory words are 32 bits wide, and addresses are byte addresses.

Top module: `win_fetch_agen`

## Requirements
- R1: After reset, `req_valid` and `done` are both low.
- R2: Bursts are at most 16 words long when `cfg_whole_w` is 128 or more, and at most 8 words long when it is below 128. No request ever has a length of zero.
- R3: Pixel code 0 means 16-bit RGB565, which is 2 bytes per pixel. Code 1 means 24-bit colour unpacked into a 32-bit word, code 2 means 32-bit with alpha, and any other code falls back to the unpacked 24-bit mode. Codes 1 and 2 and the fallback all use 4 bytes per pixel.
- R4: The first request of a frame has address `cfg_base + (cfg_off_y*cfg_whole_w + cfg_off_x)*bpp`, where bpp is the bytes per pixel from R3.
- R5: Within a line, each burst starts `4*len` bytes after the previous burst.
- R6: A line is covered by ceil(`cfg_ovl_w`*bpp/4) words. Every burst is full length except the last one of the line, which is shortened so that the line total is exact.
- R7: Each row starts `cfg_whole_w*bpp` bytes after the start of the previous row, and `cfg_ovl_h` rows are fetched.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_len` hold their values.
- R9: Once the last burst of the last row is accepted, `req_valid` falls and `done` rises. `done` then stays high and no request is made until `frame_start`.
- R10: `frame_start` restarts the walk from the first burst of row 0 and clears `done`, even in the middle of a frame.
- R11: If `cfg_ovl_w` or `cfg_ovl_h` is zero, `done` rises one cycle after `frame_start` and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a frame walk |
| cfg_base | input | AW | Byte address of the buffer origin |
| cfg_whole_w | input | CW | Padded buffer width in pixels (line pitch) |
| cfg_off_x | input | CW | Column where reading starts |
| cfg_off_y | input | CW | Row where reading starts |
| cfg_ovl_w | input | CW | Visible overlay width in pixels |
| cfg_ovl_h | input | CW | Visible overlay height in rows |
| cfg_fmt | input | 3 | Pixel storage code |
| req_valid | output | 1 | A burst request is pending |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | AW | Byte address of the burst |
| req_len | output | LENW | Burst length in 32-bit words |
| done | output | 1 | Frame walk finished |

## Verification
Several geometries are run, and the bench checks each accepted burst against a list it computes itself. A 40-pixel unpacked line on a wide buffer shows the 16-word case and a shortened tail. A 37-pixel RGB565 line on a 100-pixel buffer with stalls every other cycle shows the 8-word case, rounding of a half-filled last word, and hold under back-pressure. An unknown pixel code with non-zero offsets on a 127-pixel buffer checks the fallback mode and the offset arithmetic, and a 128-pixel buffer sits exactly on the length threshold. Separate runs check a zero-height frame, a restart in the middle of a frame, and that `done` is held idle after a frame.

// File: rtl/win_fetch_agen.sv
module win_fetch_agen #(
  parameter int AW           = 32,
  parameter int CW           = 12,
  parameter int NARROW_LIMIT = 128,
  parameter int LONG_BURST   = 16,
  parameter int SHORT_BURST  = 8,
  localparam int LENW        = $clog2(LONG_BURST + 1),
  localparam int PW          = 2 * CW + 1,
  localparam int BW          = PW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [AW-1:0]   cfg_base,
  input  logic [CW-1:0]   cfg_whole_w,
  input  logic [CW-1:0]   cfg_off_x,
  input  logic [CW-1:0]   cfg_off_y,
  input  logic [CW-1:0]   cfg_ovl_w,
  input  logic [CW-1:0]   cfg_ovl_h,
  input  logic [2:0]      cfg_fmt,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [AW-1:0]   req_addr,
  output logic [LENW-1:0] req_len,
  output logic            done
);
  localparam logic [2:0] FMT_RGB565 = 3'd0;

  logic            busy, done_q;
  logic [CW-1:0]   row;
  logic [CW:0]     left;
  logic [AW-1:0]   addr, line_addr;

  logic            wide;
  logic [CW+1:0]   line_bytes, stride;
  logic [CW:0]     line_words, burst_ext;
  logic [LENW-1:0] burst_max, cur_len;
  logic [PW-1:0]   pix_ofs;
  logic [BW-1:0]   byte_ofs;
  logic [AW-1:0]   frame_base, next_line;
  logic            empty, last_chunk, last_row, accept;

  assign wide       = (cfg_fmt != FMT_RGB565);
  assign line_bytes = wide ? {cfg_ovl_w, 2'b00} : {1'b0, cfg_ovl_w, 1'b0};
  assign stride     = wide ? {cfg_whole_w, 2'b00} : {1'b0, cfg_whole_w, 1'b0};
  assign line_words = (CW+1)'((line_bytes + (CW+2)'(3)) >> 2);
  assign burst_max  = (cfg_whole_w < CW'(NARROW_LIMIT)) ? LENW'(SHORT_BURST) : LENW'(LONG_BURST);
  assign burst_ext  = (CW+1)'(burst_max);
  assign pix_ofs    = PW'(cfg_off_y) * PW'(cfg_whole_w) + PW'(cfg_off_x);
  assign byte_ofs   = wide ? {pix_ofs, 2'b00} : {1'b0, pix_ofs, 1'b0};
  assign frame_base = cfg_base + AW'(byte_ofs);
  assign next_line  = line_addr + AW'(stride);
  assign empty      = (cfg_ovl_w == '0) || (cfg_ovl_h == '0);

  assign last_chunk = (left <= burst_ext);
  assign cur_len    = last_chunk ? LENW'(left) : burst_max;
  assign last_row   = (row == cfg_ovl_h - CW'(1));
  assign accept     = busy && req_ready;

  assign req_valid  = busy;
  assign req_addr   = addr;
  assign req_len    = cur_len;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done_q    <= 1'b0;
      row       <= '0;
      left      <= '0;
      addr      <= '0;
      line_addr <= '0;
    end else if (frame_start) begin
      busy      <= !empty;
      done_q    <= empty;
      row       <= '0;
      left      <= line_words;
      addr      <= frame_base;
      line_addr <= frame_base;
    end else if (accept) begin
      if (!last_chunk) begin
        left <= left - burst_ext;
        addr <= addr + AW'({cur_len, 2'b00});
      end else if (last_row) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
      end else begin
        row       <= row + CW'(1);
        left      <= line_words;
        line_addr <= next_line;
        addr      <= next_line;
      end
    end
  end
endmodule

// File: rtl/win_fetch_agen_chk.sv
module win_fetch_agen_chk #(
  parameter int AW = 32,
  parameter int CW = 12,
  parameter int NARROW_LIMIT = 128,
  parameter int LONG_BURST = 16,
  parameter int SHORT_BURST = 8,
  parameter int LENW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_start,
  input logic [CW-1:0]   cfg_whole_w,
  input logic [CW-1:0]   cfg_ovl_w,
  input logic [CW-1:0]   cfg_ovl_h,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic [LENW-1:0] req_len,
  input logic            done
);
  p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) &&
      (req_len <= ((cfg_whole_w < CW'(NARROW_LIMIT)) ? LENW'(SHORT_BURST) : LENW'(LONG_BURST))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !frame_start |=> req_valid && $stable(req_addr) && $stable(req_len));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && done));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !frame_start |=> done && !req_valid);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && cfg_ovl_w != '0 && cfg_ovl_h != '0 |=> req_valid && !done);

  p_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && (cfg_ovl_w == '0 || cfg_ovl_h == '0) |=> done && !req_valid);
endmodule

bind win_fetch_agen win_fetch_agen_chk #(
  .AW(AW), .CW(CW), .NARROW_LIMIT(NARROW_LIMIT),
  .LONG_BURST(LONG_BURST), .SHORT_BURST(SHORT_BURST), .LENW(LENW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .cfg_whole_w(cfg_whole_w), .cfg_ovl_w(cfg_ovl_w), .cfg_ovl_h(cfg_ovl_h),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_len(req_len), .done(done)
);

// File: tb/sim_win_fetch_agen.sv
module sim_win_fetch_agen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 12;
  localparam int LENW = 5;

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, req_ready = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [CW-1:0] cfg_whole_w = '0, cfg_off_x = '0, cfg_off_y = '0, cfg_ovl_w = '0, cfg_ovl_h = '0;
  logic [2:0] cfg_fmt = '0;
  logic req_valid, done;
  logic [AW-1:0] req_addr;
  logic [LENW-1:0] req_len;

  int n_chk = 0, n_fail = 0;
  int exp_addr [256];
  int exp_len  [256];
  int n_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_fetch_agen u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_base(cfg_base),
    .cfg_whole_w(cfg_whole_w), .cfg_off_x(cfg_off_x), .cfg_off_y(cfg_off_y),
    .cfg_ovl_w(cfg_ovl_w), .cfg_ovl_h(cfg_ovl_h), .cfg_fmt(cfg_fmt),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic configure(input int base, input int wx, input int ox, input int oy,
                           input int ow, input int oh, input int fmt);
    cfg_base = AW'(base); cfg_whole_w = CW'(wx); cfg_off_x = CW'(ox);
    cfg_off_y = CW'(oy); cfg_ovl_w = CW'(ow); cfg_ovl_h = CW'(oh); cfg_fmt = 3'(fmt);
  endtask

  task automatic build_expect(input int base, input int wx, input int ox, input int oy,
                              input int ow, input int oh, input int fmt);
    int bpp = (fmt == 0) ? 2 : 4;
    int words = (ow * bpp + 3) / 4;
    int bmax = (wx < 128) ? 8 : 16;
    n_exp = 0;
    for (int r = 0; r < oh; r++) begin
      int a = base + ((oy + r) * wx + ox) * bpp;
      int lft = words;
      while (lft > 0) begin
        int l = (lft > bmax) ? bmax : lft;
        exp_addr[n_exp] = a; exp_len[n_exp] = l; n_exp++;
        a += 4 * l; lft -= l;
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); req_ready = 1'b0; frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // pattern 0: always ready, 1: every other cycle, 2: one cycle in three
  task automatic run_frame(input string tag, input int pat);
    int k = 0, cyc = 0, mism = 0;
    bit prev_stall = 0;
    logic [AW-1:0] pa = '0;
    logic [LENW-1:0] pl = '0;
    pulse_start();
    while (!done && cyc < 5000) begin
      if (prev_stall) chk(req_valid && req_addr == pa && req_len == pl, "R8", "held request",
                          longint'(req_addr), longint'(pa));
      req_ready = (pat == 0) || (pat == 1 && cyc % 2 == 1) || (pat == 2 && cyc % 3 == 2);
      if (req_valid && req_ready) begin
        if (k < n_exp) begin
          if (req_addr != AW'(exp_addr[k]) || req_len != LENW'(exp_len[k])) begin
            mism++;
            $display("FAIL %s burst %0d: actual addr %0d len %0d expected addr %0d len %0d",
                     tag, k, req_addr, req_len, exp_addr[k], exp_len[k]);
          end
        end
        k++;
      end
      prev_stall = req_valid && !req_ready;
      pa = req_addr; pl = req_len;
      cyc++;
      @(negedge clk);
    end
    req_ready = 1'b0;
    n_chk++;
    if (mism != 0) n_fail++;
    chk(k == n_exp, tag, "burst count", k, n_exp);
    chk(done && !req_valid, "R9", "done after last burst", {done, req_valid}, 2);
  endtask

  task automatic t_reset();
    chk(!req_valid && !done, "R1", "reset outputs", {req_valid, done}, 0);
  endtask

  task automatic t_wide_unpacked();
    configure(32'h1000, 200, 0, 0, 40, 3, 1);
    build_expect(32'h1000, 200, 0, 0, 40, 3, 1);
    run_frame("R2 R4 R5 R6 R7", 0);
  endtask

  task automatic t_narrow_565_stall();
    configure(32'h2000, 100, 3, 1, 37, 2, 0);
    build_expect(32'h2000, 100, 3, 1, 37, 2, 0);
    run_frame("R2 R3 R6 R8", 1);
  endtask

  task automatic t_fallback_code();
    configure(32'h4000, 127, 5, 2, 20, 2, 5);
    build_expect(32'h4000, 127, 5, 2, 20, 2, 5);
    run_frame("R3 R4", 2);
  endtask

  task automatic t_threshold();
    configure(32'h8000, 128, 1, 0, 16, 2, 2);
    build_expect(32'h8000, 128, 1, 0, 16, 2, 2);
    run_frame("R2 boundary", 0);
  endtask

  task automatic t_done_hold();
    req_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(done && !req_valid, "R9", "done held idle", {done, req_valid}, 2);
    req_ready = 1'b0;
  endtask

  task automatic t_empty();
    configure(32'h100, 200, 0, 0, 10, 0, 1);
    pulse_start();
    chk(done && !req_valid, "R11", "zero height", {done, req_valid}, 2);
    configure(32'h100, 200, 0, 0, 0, 4, 1);
    pulse_start();
    chk(done && !req_valid, "R11", "zero width", {done, req_valid}, 2);
  endtask

  task automatic t_restart();
    configure(32'h3000, 300, 2, 2, 64, 4, 1);
    build_expect(32'h3000, 300, 2, 2, 64, 4, 1);
    pulse_start();
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    req_ready = 1'b0;
    chk(req_addr != AW'(exp_addr[0]), "R10", "walk advanced", longint'(req_addr), exp_addr[3]);
    pulse_start();
    chk(req_valid && !done && req_addr == AW'(exp_addr[0]) && req_len == LENW'(exp_len[0]),
        "R10", "restart address", longint'(req_addr), exp_addr[0]);
    run_frame("R10 full frame", 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_unpacked();
    t_done_hold();
    t_narrow_565_stall();
    t_fallback_code();
    t_threshold();
    t_empty();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule